// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Monitor

This block watches the control pins of a synchronous DRAM and samples them on every rising clock edge. It turns the pin pattern into a command code and tracks the open or closed state of each bank. It also tracks whether the whole device is running normally, sitting in self refresh, or powered down. It sits beside a memory controller or a bus model and flags any command that the device could not accept in its current state.

Each decode uses two clock-enable samples: the one taken on the previous edge and the one taken now. This is what separates self-refresh and power-down entry and exit from ordinary commands. Ordinary commands are also checked against the state of the bank they address. The data-mask pin is turned into a data output enable and a write mask whenever a bank is open. All outputs are registered and describe the cycle sampled on the latest edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset, all banks are idle, `dev_mode_o` is 0 (normal), `cmd_code_o` is 0, and `data_oe_o`, `wr_mask_o` and `illegal_o` are 0. The clock enable of the cycle before the first edge is taken as high.
- R2: In normal mode, with clock enable high on both the previous and the current edge and `cs_n` low, {ras_n,cas_n,we_n} decode as follows: 111 → NOP (code 0), 110 → burst stop (6), 101 → read (3), 100 → write (4), 011 → activate (2), 010 → precharge (5), 001 → auto refresh (8), 000 → mode register set (7). Every output appears one clock after the edge that samples the pins.
- R3: `cs_n` high decodes as deselect (code 1) whatever the other command pins are, and it is never illegal.
- R4: Activate is legal only when the bank selected by `ba_i` is idle. A legal activate opens that bank.
- R5: Read and write are legal only when the selected bank is open. With `a10_i` high, the access closes that bank (auto-precharge). With `a10_i` low, the bank stays open.
- R6: Precharge is always legal. With `a10_i` high it closes all banks. With `a10_i` low it closes only the selected bank.
- R7: Burst stop needs at least one open bank. Mode register set and auto refresh need all banks idle.
- R8: Self-refresh entry (code 9) is `cs_n` low with pattern 001, clock enable high before and low now. It is legal only with all banks idle, and it sets mode 1. Exit (code 10) is clock enable low before and high now, with deselect or NOP. Exit returns the mode to 0.
- R9: Power-down entry (code 11) is clock enable going from high to low with deselect or NOP. It is legal with banks open or idle, and it sets mode 2. Exit (code 12) is clock enable going from low to high with deselect or NOP. Exit returns the mode to 0 and leaves the banks untouched.
- R10: In mode 1 or 2, every cycle other than a valid exit reports code 13, is not illegal, and changes neither the banks nor the mode.
- R11: An illegal command raises `illegal_o` for that cycle only and leaves the bank and mode state unchanged. In normal mode, these clock-enable cases report code 14 and are illegal: a falling clock enable with any pattern other than deselect, NOP or 001, and a previous clock enable that was low.
- R12: When at least one bank was open before the edge, `data_oe_o` equals the inverse of `dqm_i` and `wr_mask_o` equals `dqm_i`, whatever the command and clock-enable pins are. With no bank open, both are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| dqm_i | input | 1 | Data mask |
| ba_i | input | 2 | Bank select |
| a10_i | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| cmd_code_o | output | 4 | Decoded command code |
| bank_active_o | output | 4 | One bit per bank, high while the bank is open |
| dev_mode_o | output | 2 | 0 normal, 1 self refresh, 2 power down |
| data_oe_o | output | 1 | Data output or write enabled |
| wr_mask_o | output | 1 | Output disabled or write data masked |
| illegal_o | output | 1 | Command not allowed in the current state |

## Verification
The decoder is driven with each of the eight command patterns, both with no bank open and with banks open, so that legal and illegal use of the same pins is told apart. Chip select high is combined with several different strobe values to show that deselect masks them. All four combinations of the previous and current clock enable are applied with deselect, NOP, the refresh pattern and a read pattern, in normal, power-down and self-refresh modes. This separates entry, exit, ignored cycles and clock-enable misuse. The data mask is toggled with banks open and closed, including during power down, to confirm that it does not depend on the command pins.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_DESEL    = 4'd1,
        CMD_ACT      = 4'd2,
        CMD_READ     = 4'd3,
        CMD_WRITE    = 4'd4,
        CMD_PRE      = 4'd5,
        CMD_BST      = 4'd6,
        CMD_MRS      = 4'd7,
        CMD_AREF     = 4'd8,
        CMD_SREF_IN  = 4'd9,
        CMD_SREF_OUT = 4'd10,
        CMD_PDN_IN   = 4'd11,
        CMD_PDN_OUT  = 4'd12,
        CMD_IGNORED  = 4'd13,
        CMD_BAD      = 4'd14
    } sdcm_cmd_e;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_SELFREF = 2'd1,
        MODE_PWRDN   = 2'd2
    } sdcm_mode_e;

    typedef enum logic [1:0] {
        BANK_IDLE = 2'b00,
        BANK_OPEN = 2'b01
    } sdcm_bank_e;

    typedef enum logic [3:0] {
        PAT_NOP,
        PAT_BST,
        PAT_READ,
        PAT_WRITE,
        PAT_ACT,
        PAT_PRE,
        PAT_REF,
        PAT_MRS,
        PAT_DESEL
    } sdcm_pat_e;

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
    import sdcm_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output sdcm_pat_e pat_o
);

    always_comb begin
        if (cs_n) begin
            pat_o = PAT_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  pat_o = PAT_NOP;
                3'b110:  pat_o = PAT_BST;
                3'b101:  pat_o = PAT_READ;
                3'b100:  pat_o = PAT_WRITE;
                3'b011:  pat_o = PAT_ACT;
                3'b010:  pat_o = PAT_PRE;
                3'b001:  pat_o = PAT_REF;
                default: pat_o = PAT_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdcm_policy.sv
module sdcm_policy
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  sdcm_pat_e              pat_i,
    input  logic                   cke_prev_i,
    input  logic                   cke_i,
    input  sdcm_mode_e             mode_i,
    input  logic [NUM_BANKS-1:0]   bank_open_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic                   a10_i,
    output sdcm_cmd_e              code_o,
    output logic                   illegal_o,
    output logic [NUM_BANKS-1:0]   open_o,
    output logic [NUM_BANKS-1:0]   close_o,
    output sdcm_mode_e             mode_o
);

    logic [NUM_BANKS-1:0] sel;
    logic                 any_open;
    logic                 tgt_open;
    logic                 quiet_pat;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        assign sel[g] = (ba_i == BA_W'(g));
    end

    assign any_open  = |bank_open_i;
    assign tgt_open  = |(bank_open_i & sel);
    assign quiet_pat = (pat_i == PAT_DESEL) || (pat_i == PAT_NOP);

    always_comb begin
        code_o    = CMD_BAD;
        illegal_o = 1'b0;
        open_o    = '0;
        close_o   = '0;
        mode_o    = mode_i;
        if (mode_i != MODE_NORMAL) begin
            if (!cke_prev_i && cke_i && quiet_pat) begin
                code_o = (mode_i == MODE_SELFREF) ? CMD_SREF_OUT : CMD_PDN_OUT;
                mode_o = MODE_NORMAL;
            end else begin
                code_o = CMD_IGNORED;
            end
        end else if (!cke_prev_i) begin
            code_o    = CMD_BAD;
            illegal_o = 1'b1;
        end else if (!cke_i) begin
            if (pat_i == PAT_REF) begin
                code_o = CMD_SREF_IN;
                if (any_open) illegal_o = 1'b1;
                else          mode_o    = MODE_SELFREF;
            end else if (quiet_pat) begin
                code_o = CMD_PDN_IN;
                mode_o = MODE_PWRDN;
            end else begin
                code_o    = CMD_BAD;
                illegal_o = 1'b1;
            end
        end else begin
            unique case (pat_i)
                PAT_DESEL: code_o = CMD_DESEL;
                PAT_NOP:   code_o = CMD_NOP;
                PAT_ACT: begin
                    code_o = CMD_ACT;
                    if (tgt_open) illegal_o = 1'b1;
                    else          open_o    = sel;
                end
                PAT_READ, PAT_WRITE: begin
                    code_o = (pat_i == PAT_READ) ? CMD_READ : CMD_WRITE;
                    if (!tgt_open)  illegal_o = 1'b1;
                    else if (a10_i) close_o   = sel;
                end
                PAT_PRE: begin
                    code_o  = CMD_PRE;
                    close_o = a10_i ? '1 : sel;
                end
                PAT_BST: begin
                    code_o = CMD_BST;
                    if (!any_open) illegal_o = 1'b1;
                end
                PAT_MRS: begin
                    code_o = CMD_MRS;
                    if (any_open) illegal_o = 1'b1;
                end
                default: begin
                    code_o = CMD_AREF;
                    if (any_open) illegal_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
    import sdcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic active_o
);

    sdcm_bank_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (open_i)       state_d = BANK_OPEN;
        else if (close_i) state_d = BANK_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BANK_IDLE;
        else        state_q <= state_d;
    end

    assign active_o = (state_q == BANK_OPEN);

    // R4: the policy only opens a bank that is currently idle
    a_r4_open_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |-> (state_q == BANK_IDLE));

    // R6: open and close are never requested together
    a_r6_no_open_close: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && close_i));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke_i,
    input  logic                 dqm_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output logic [3:0]           cmd_code_o,
    output logic [NUM_BANKS-1:0] bank_active_o,
    output logic [1:0]           dev_mode_o,
    output logic                 data_oe_o,
    output logic                 wr_mask_o,
    output logic                 illegal_o
);

    typedef struct packed {
        logic       cke_prev;
        sdcm_cmd_e  code;
        sdcm_mode_e mode;
        logic       oe;
        logic       mask;
        logic       bad;
    } mon_t;

    mon_t mon_d, mon_q;

    sdcm_pat_e            pat;
    sdcm_cmd_e            pol_code;
    sdcm_mode_e           pol_mode;
    logic                 pol_bad;
    logic [NUM_BANKS-1:0] open_v;
    logic [NUM_BANKS-1:0] close_v;
    logic [NUM_BANKS-1:0] bank_q;

    sdcm_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .pat_o (pat)
    );

    sdcm_policy #(.NUM_BANKS(NUM_BANKS)) u_policy (
        .pat_i       (pat),
        .cke_prev_i  (mon_q.cke_prev),
        .cke_i       (cke_i),
        .mode_i      (mon_q.mode),
        .bank_open_i (bank_q),
        .ba_i        (ba_i),
        .a10_i       (a10_i),
        .code_o      (pol_code),
        .illegal_o   (pol_bad),
        .open_o      (open_v),
        .close_o     (close_v),
        .mode_o      (pol_mode)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdcm_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_i   (open_v[g]),
            .close_i  (close_v[g]),
            .active_o (bank_q[g])
        );
    end

    always_comb begin
        mon_d          = mon_q;
        mon_d.cke_prev = cke_i;
        mon_d.code     = pol_code;
        mon_d.mode     = pol_mode;
        mon_d.bad      = pol_bad;
        mon_d.oe       = (|bank_q) & ~dqm_i;
        mon_d.mask     = (|bank_q) & dqm_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '{cke_prev: 1'b1, code: CMD_NOP, mode: MODE_NORMAL,
                       oe: 1'b0, mask: 1'b0, bad: 1'b0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign cmd_code_o    = mon_q.code;
    assign bank_active_o = bank_q;
    assign dev_mode_o    = mon_q.mode;
    assign data_oe_o     = mon_q.oe;
    assign wr_mask_o     = mon_q.mask;
    assign illegal_o     = mon_q.bad;

    // R11: a flagged command leaves bank and mode state as it was
    a_r11_illegal_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (bank_active_o == $past(bank_active_o)) &&
                      (dev_mode_o == $past(dev_mode_o)));

    // R12: output enable and write mask never both high
    a_r12_oe_mask_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_oe_o && wr_mask_o));

    // R8: self refresh is only ever held with every bank idle
    a_r8_selfref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode_o == 2'd1) |-> (bank_active_o == '0));

    // R10: ignored low-power cycles are silent and change nothing
    a_r10_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code_o == 4'd13) |-> !illegal_o && $stable(bank_active_o) &&
                                  $stable(dev_mode_o));

    // R3: deselect is never reported as illegal
    a_r3_desel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code_o == 4'd1) |-> !illegal_o);

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke = 1'b1, dqm = 1'b0, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_code;
    logic [3:0] bank_active;
    logic [1:0] dev_mode;
    logic       data_oe, wr_mask, illegal;

    always #10 clk = ~clk;

    sdram_cmd_monitor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .cke_i         (cke),
        .dqm_i         (dqm),
        .ba_i          (ba),
        .a10_i         (a10),
        .cmd_code_o    (cmd_code),
        .bank_active_o (bank_active),
        .dev_mode_o    (dev_mode),
        .data_oe_o     (data_oe),
        .wr_mask_o     (wr_mask),
        .illegal_o     (illegal)
    );

    typedef struct {
        logic [3:0] code;
        logic [3:0] banks;
        logic [1:0] mode;
        logic       oe;
        logic       mask;
        logic       bad;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // reference state built from the requirements
    logic [3:0] m_banks = 4'b0;
    logic [1:0] m_mode  = 2'd0;
    logic       m_ckp   = 1'b1;

    function automatic void cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endfunction

    // pins: cs ras cas we cke dqm ba a10
    task automatic step(input logic c, r, s, w, k, d, input logic [1:0] b,
                        input logic a, input string tag);
        exp_t       e;
        int         p;
        logic [3:0] sel;
        logic       any, tgt, quiet;
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; dqm = d; ba = b; a10 = a;
        p     = c ? 8 : int'({r, s, w});   // 8 deselect, else 3-bit pattern
        sel   = 4'b1 << b;
        any   = |m_banks;
        tgt   = |(m_banks & sel);
        quiet = (p == 8) || (p == 7);
        e.tag = tag; e.bad = 1'b0;
        e.oe  = any & ~d; e.mask = any & d;
        if (m_mode != 2'd0) begin
            if (!m_ckp && k && quiet) begin
                e.code = (m_mode == 2'd1) ? 4'd10 : 4'd12; m_mode = 2'd0;
            end else e.code = 4'd13;
        end else if (!m_ckp) begin
            e.code = 4'd14; e.bad = 1'b1;
        end else if (!k) begin
            if (p == 1) begin
                e.code = 4'd9;
                if (any) e.bad = 1'b1; else m_mode = 2'd1;
            end else if (quiet) begin
                e.code = 4'd11; m_mode = 2'd2;
            end else begin
                e.code = 4'd14; e.bad = 1'b1;
            end
        end else begin
            case (p)
                8: e.code = 4'd1;
                7: e.code = 4'd0;
                3: begin e.code = 4'd2; if (tgt) e.bad = 1'b1; else m_banks |= sel; end
                5, 4: begin
                    e.code = (p == 5) ? 4'd3 : 4'd4;
                    if (!tgt) e.bad = 1'b1; else if (a) m_banks &= ~sel;
                end
                2: begin e.code = 4'd5; m_banks = a ? 4'b0 : (m_banks & ~sel); end
                6: begin e.code = 4'd6; if (!any) e.bad = 1'b1; end
                0: begin e.code = 4'd7; if (any) e.bad = 1'b1; end
                default: begin e.code = 4'd8; if (any) e.bad = 1'b1; end
            endcase
        end
        m_ckp   = k;
        e.banks = m_banks;
        e.mode  = m_mode;
        q.push_back(e);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "code",    cmd_code,    e.code);
            cmp(e.tag, "banks",   bank_active, e.banks);
            cmp(e.tag, "mode",    dev_mode,    e.mode);
            cmp(e.tag, "oe",      data_oe,     e.oe);
            cmp(e.tag, "mask",    wr_mask,     e.mask);
            cmp(e.tag, "illegal", illegal,     e.bad);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        cmp("R1", "code", cmd_code, 0);
        cmp("R1", "banks", bank_active, 0);
        cmp("R1", "mode", dev_mode, 0);
        cmp("R1", "oe/mask/illegal", {data_oe, wr_mask, illegal}, 0);

        step(0,1,1,1, 1,0, 2'd0,0, "R2");   // NOP
        step(1,0,0,0, 1,0, 2'd0,0, "R3");   // deselect masks pattern 000
        step(1,0,1,1, 1,1, 2'd2,1, "R3");   // deselect masks pattern 011
        step(0,1,1,0, 1,0, 2'd0,0, "R7");   // burst stop, nothing open: illegal
        step(0,0,1,1, 1,0, 2'd0,0, "R4");   // activate bank 0
        step(0,0,1,1, 1,0, 2'd0,0, "R11");  // activate open bank: illegal
        step(0,1,0,1, 1,0, 2'd0,0, "R5");   // read bank 0, stays open
        step(0,1,0,0, 1,0, 2'd1,0, "R5");   // write closed bank 1: illegal
        step(0,1,1,1, 1,1, 2'd0,0, "R12");  // dqm high with bank open
        step(0,1,1,0, 1,0, 2'd3,0, "R7");   // burst stop, legal
        step(0,0,0,0, 1,0, 2'd0,0, "R7");   // mode register set with open bank
        step(0,0,0,1, 1,0, 2'd0,0, "R7");   // auto refresh with open bank
        step(0,0,1,1, 1,0, 2'd2,0, "R4");   // activate bank 2
        step(0,0,1,0, 1,0, 2'd0,0, "R6");   // precharge bank 0 only
        step(0,0,1,1, 1,1, 2'd3,0, "R4");   // activate bank 3
        step(0,0,1,0, 1,0, 2'd1,1, "R6");   // precharge all
        step(0,1,0,1, 1,0, 2'd2,0, "R5");   // read closed bank 2: illegal
        step(0,0,1,0, 1,0, 2'd1,0, "R6");   // precharge idle bank: legal
        step(0,0,0,0, 1,1, 2'd0,0, "R7");   // mode register set, all idle
        step(0,0,0,1, 1,1, 2'd0,0, "R7");   // auto refresh, all idle
        step(0,0,1,1, 1,0, 2'd3,0, "R4");
        step(0,1,0,0, 1,0, 2'd3,1, "R5");   // write with auto-precharge
        step(0,0,1,1, 1,0, 2'd1,0, "R4");   // activate bank 1
        step(0,1,1,1, 0,0, 2'd0,0, "R9");   // power-down entry, bank open
        step(0,1,0,1, 0,1, 2'd1,0, "R10");  // read pattern ignored, dqm R12
        step(0,0,1,1, 1,0, 2'd0,0, "R10");  // rising cke with activate: ignored
        step(0,1,1,1, 0,0, 2'd0,0, "R10");  // ignored
        step(1,0,0,0, 1,1, 2'd0,0, "R9");   // power-down exit via deselect
        step(0,0,0,1, 0,0, 2'd0,0, "R8");   // self refresh with open bank: illegal
        step(0,1,1,1, 1,0, 2'd0,0, "R11");  // previous cke low in normal mode
        step(0,0,1,0, 1,0, 2'd0,1, "R6");   // precharge all
        step(0,0,0,1, 0,0, 2'd0,0, "R8");   // self-refresh entry
        step(0,0,1,1, 0,0, 2'd2,0, "R10");  // ignored
        step(0,0,0,1, 0,0, 2'd0,0, "R10");  // ignored
        step(0,1,1,1, 1,0, 2'd0,0, "R8");   // self-refresh exit via NOP
        step(0,1,0,1, 0,0, 2'd0,0, "R11");  // falling cke with read pattern
        step(0,1,1,1, 1,0, 2'd0,0, "R11");  // previous cke low: illegal
        step(0,1,1,1, 1,0, 2'd0,0, "R2");
        step(1,1,1,1, 0,0, 2'd0,0, "R9");   // power-down entry via deselect
        step(0,1,1,1, 1,0, 2'd0,0, "R9");   // exit via NOP
        step(0,1,1,1, 1,0, 2'd0,0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule